// File: doc/BRIEF.md
# Framed Word Serializer with Run-Start Marking

This block turns a stream of 18-bit parallel words into a serial bit stream, one bit per cycle of a single fast bit clock. It wraps each word in a 20-bit frame: a start bit, the 18 payload bits sent least significant first, and a stop bit. The block times the frames itself and gives the word side a one-cycle capture strobe and a derived word clock, so the word-rate logic never needs a second clock domain.

A sync request replaces the payload with a fixed alignment pattern. The line then carries a run of ten ones followed by a run of ten zeros, which a receiver can lock onto immediately. For each serial bit, a marker output says whether that bit opens a new run of equal values, so an emphasis driver can boost it.

A loopback control moves the stream from the external driver to an internal self-test path and switches the external output off.

Top module: `sfw_serializer`

## Requirements
- R1: `word_tick_o` is high for exactly one cycle in every 20. The payload and sync inputs are captured on the rising clock edge that ends a tick cycle, and that frame starts on the next cycle.
- R2: Frame position 0 (the cycle after a tick) carries the start bit, value 1.
- R3: Frame position 19 (the tick cycle itself) carries the stop bit, value 0.
- R4: Frame positions 1 to 18 carry the captured payload bits 0 to 17, in that order.
- R5: When sync is high at capture, positions 1 to 9 carry 1 and positions 10 to 18 carry 0, whatever the payload. Sync high at any other edge has no effect.
- R6: Changes to the payload or to sync between capture edges do not alter the frame in flight.
- R7: `emph_o` is 1 exactly when the current serial bit differs from the previous one. The bit before the first frame after reset counts as 0.
- R8: With `loop_en_i` high, `loop_o` carries the stream while `ser_o` is 0 and `ser_oe_o` is 0. With it low, `ser_o` carries the stream, `ser_oe_o` is 1 and `loop_o` is 0. The switch takes effect in the same cycle.
- R9: In the cycle after any clock edge where reset is low, `ser_o`, `loop_o` and `emph_o` are 0 and `word_tick_o` is 1. The first frame after reset therefore starts one cycle after release.
- R10: `word_clk_o` is high in frame positions 0 to 9 and low in positions 10 to 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_i | input | 18 | Payload word, captured at the end of a tick cycle |
| sync_i | input | 1 | Request the alignment pattern for the next frame |
| loop_en_i | input | 1 | Route the stream to the internal loop path |
| word_tick_o | output | 1 | Capture strobe, one cycle per frame |
| word_clk_o | output | 1 | Bit clock divided by 20 |
| ser_o | output | 1 | External serial data |
| ser_oe_o | output | 1 | External driver enable |
| loop_o | output | 1 | Internal loopback serial data |
| emph_o | output | 1 | First bit of a run of equal bits |

## Verification
The bench sends alternating, all-ones, all-zeros and single-bit words. On these, a marker that misses a run boundary, or flags every bit, shows up at once. It also checks the boundary between frames, where a swapped start or stop level would merge runs across frames.

Sync and payload are disturbed mid-frame. A design that samples them anywhere but the capture edge would corrupt the frame in flight, and a design that reverses the bit order would put the alignment pattern upside down.

Reset is asserted in the middle of a frame. A counter that restarted at the wrong phase would delay or truncate the first frame, and loopback frames check that the external pin is muted while the loop path still carries the stream.

// File: rtl/sfw_pkg.sv
// Package: shared line levels and default sizes for the framed serializer.
// Assumes a frame is always one start bit, the payload, and one stop bit.
package sfw_pkg;
    localparam int unsigned DEF_PAYLOAD_W = 18;
    localparam logic        START_LVL     = 1'b1;
    localparam logic        STOP_LVL      = 1'b0;
endpackage

// File: rtl/sfw_frame_timer.sv
// Frame timer: counts bit positions within a frame and produces the capture
// strobe and a half-duty word clock. Assumes FRAME_W >= 2. During reset it
// sits on the last position, so the first edge after release loads a frame.
module sfw_frame_timer #(
    parameter int unsigned FRAME_W = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o,
    output logic word_clk_o
);
    localparam int unsigned       POS_W = $clog2(FRAME_W);
    localparam logic [POS_W-1:0]  LAST  = POS_W'(FRAME_W - 1);
    localparam logic [POS_W-1:0]  HALF  = POS_W'(FRAME_W / 2);

    logic [POS_W-1:0] pos_q;

    // Advance the bit position and wrap at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)            pos_q <= LAST;
        else if (pos_q == LAST) pos_q <= '0;
        else                   pos_q <= pos_q + POS_W'(1);
    end

    assign load_o     = (pos_q == LAST);
    assign word_clk_o = (pos_q < HALF);
endmodule

// File: rtl/sfw_frame_loader.sv
// Frame loader: builds the start/payload/stop frame, substituting the
// alignment word on request, and shifts it out LSB first. Assumes load_o from
// the timer marks the last bit of the previous frame.
module sfw_frame_loader
    import sfw_pkg::*;
#(
    parameter int unsigned PAYLOAD_W = DEF_PAYLOAD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [PAYLOAD_W-1:0] word_i,
    input  logic                 sync_i,
    output logic                 bit_o
);
    localparam int unsigned          FRAME_W   = PAYLOAD_W + 2;
    localparam int unsigned          ONES_N    = PAYLOAD_W / 2;
    localparam logic [PAYLOAD_W-1:0] SYNC_WORD = PAYLOAD_W'((64'd1 << ONES_N) - 64'd1);

    logic [PAYLOAD_W-1:0] word_sel;
    logic [FRAME_W-1:0]   frame;
    logic [FRAME_W-1:0]   shreg_q;

    assign word_sel = sync_i ? SYNC_WORD : word_i;

    assign frame[0]         = START_LVL;
    assign frame[FRAME_W-1] = STOP_LVL;
    for (genvar i = 0; i < PAYLOAD_W; i++) begin : g_pay
        assign frame[i+1] = word_sel[i];
    end

    // Load a fresh frame at the boundary, otherwise shift toward the output.
    always_ff @(posedge clk) begin
        if (!rst_n)      shreg_q <= {FRAME_W{STOP_LVL}};
        else if (load_i) shreg_q <= frame;
        else             shreg_q <= {STOP_LVL, shreg_q[FRAME_W-1:1]};
    end

    assign bit_o = shreg_q[0];
endmodule

// File: rtl/sfw_run_marker.sv
// Run marker: flags the bit that opens a run of equal values. Assumes the
// line sat at the stop level before the first bit after reset.
module sfw_run_marker
    import sfw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic first_o
);
    logic prev_q;

    // Remember the bit on the line in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= STOP_LVL;
        else        prev_q <= bit_i;
    end

    assign first_o = bit_i ^ prev_q;
endmodule

// File: rtl/sfw_serializer.sv
// Framed word serializer top: joins the timer, loader and run marker, and
// steers the stream to the external pin or the internal loop path. Assumes a
// single bit clock; the word side uses word_tick_o as its capture strobe.
module sfw_serializer
    import sfw_pkg::*;
#(
    parameter int unsigned PAYLOAD_W = DEF_PAYLOAD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PAYLOAD_W-1:0] word_i,
    input  logic                 sync_i,
    input  logic                 loop_en_i,
    output logic                 word_tick_o,
    output logic                 word_clk_o,
    output logic                 ser_o,
    output logic                 ser_oe_o,
    output logic                 loop_o,
    output logic                 emph_o
);
    localparam int unsigned FRAME_W = PAYLOAD_W + 2;

    logic load;
    logic stream;

    sfw_frame_timer #(.FRAME_W(FRAME_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_o     (load),
        .word_clk_o (word_clk_o)
    );

    sfw_frame_loader #(.PAYLOAD_W(PAYLOAD_W)) u_loader (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .word_i (word_i),
        .sync_i (sync_i),
        .bit_o  (stream)
    );

    sfw_run_marker u_marker (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_i   (stream),
        .first_o (emph_o)
    );

    // Route the stream: loopback mutes the external pin.
    always_comb begin
        word_tick_o = load;
        ser_oe_o    = !loop_en_i;
        ser_o       = loop_en_i ? STOP_LVL : stream;
        loop_o      = loop_en_i ? stream : STOP_LVL;
    end
endmodule

// File: rtl/sfw_serializer_chk.sv
// Checker for sfw_serializer: watches the ports for framing, marker,
// loopback and reset rules. Bound to the top below.
module sfw_serializer_chk
    import sfw_pkg::*;
#(
    parameter int unsigned FRAME_W = 20
) (
    input logic clk,
    input logic rst_n,
    input logic loop_en_i,
    input logic word_tick_o,
    input logic word_clk_o,
    input logic ser_o,
    input logic ser_oe_o,
    input logic loop_o,
    input logic emph_o
);
    localparam int unsigned      CW   = $clog2(FRAME_W);
    localparam logic [CW-1:0]    LAST = CW'(FRAME_W - 1);

    logic          stream;
    logic [CW-1:0] cnt_q;
    logic          was_rst_q;

    assign stream = loop_en_i ? loop_o : ser_o;

    // Independent frame-phase counter for tick spacing.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= LAST;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + CW'(1);
    end

    // Note whether the last edge saw reset.
    always_ff @(posedge clk) was_rst_q <= !rst_n;

    a_r1_tick_due: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST) |-> word_tick_o);
    a_r1_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        word_tick_o |-> (cnt_q == LAST));
    a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        word_tick_o |=> (stream == START_LVL));
    a_r3_stop_bit: assert property (@(posedge clk) disable iff (!rst_n)
        word_tick_o |-> (stream == STOP_LVL));
    a_r7_run_start: assert property (@(posedge clk) disable iff (!rst_n)
        emph_o == (stream != $past(stream)));
    a_r8_loop_mute: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en_i |-> (!ser_oe_o && ser_o == STOP_LVL));
    a_r8_loop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en_i |-> (ser_oe_o && loop_o == STOP_LVL));
    a_r10_wclk_rise: assert property (@(posedge clk) disable iff (!rst_n)
        word_tick_o |=> word_clk_o);

    // R9: outputs sit at the idle levels after a reset edge.
    always @(negedge clk) begin
        if (was_rst_q === 1'b1) begin
            a_r9_reset_idle: assert (ser_o == STOP_LVL && loop_o == STOP_LVL
                                     && !emph_o && word_tick_o);
        end
    end
endmodule

bind sfw_serializer sfw_serializer_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .loop_en_i   (loop_en_i),
    .word_tick_o (word_tick_o),
    .word_clk_o  (word_clk_o),
    .ser_o       (ser_o),
    .ser_oe_o    (ser_oe_o),
    .loop_o      (loop_o),
    .emph_o      (emph_o)
);

// File: tb/sfw_serializer_bench.sv
// Bench for sfw_serializer: walks a vector table frame by frame, then
// directed reset tests. Vector layout: {loop, sync, payload[17:0]}.
module sfw_serializer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] word_i = '0;
    logic        sync_i = 1'b0;
    logic        loop_en_i = 1'b0;
    logic        word_tick_o, word_clk_o, ser_o, ser_oe_o, loop_o, emph_o;

    int   checks = 0;
    int   errors = 0;
    logic exp_prev = 1'b0;

    localparam int NV = 7;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 1'b0, 18'h2AAAA},
        {1'b0, 1'b0, 18'h3FFFF},
        {1'b0, 1'b0, 18'h00000},
        {1'b0, 1'b1, 18'h12345},
        {1'b1, 1'b0, 18'h0F0F0},
        {1'b1, 1'b1, 18'h3C00F},
        {1'b0, 1'b0, 18'h00001}
    };

    always #10 clk = ~clk;

    sfw_serializer u_sfw_serializer (
        .clk(clk), .rst_n(rst_n), .word_i(word_i), .sync_i(sync_i),
        .loop_en_i(loop_en_i), .word_tick_o(word_tick_o), .word_clk_o(word_clk_o),
        .ser_o(ser_o), .ser_oe_o(ser_oe_o), .loop_o(loop_o), .emph_o(emph_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        logic [3:0] got;
        got = {ser_o, loop_o, emph_o, word_tick_o};
        chk(got === 4'b0001, tag, {28'd0, got}, 32'h1);
    endtask

    // Observe one frame of cur; disturb inputs mid-frame; present nxt at the end.
    task automatic run_frame(input logic [19:0] cur, input logic [19:0] nxt);
        logic [17:0] pl;
        logic [19:0] exp_f, got_f, exp_e, got_e, got_t, got_w;
        int bad;
        bad = 0;
        pl = cur[18] ? 18'h001FF : cur[17:0];
        exp_f = {1'b0, pl, 1'b1};
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            got_f[k] = cur[19] ? loop_o : ser_o;
            exp_e[k] = exp_f[k] ^ exp_prev;
            exp_prev = exp_f[k];
            got_e[k] = emph_o;
            got_t[k] = word_tick_o;
            got_w[k] = word_clk_o;
            if (cur[19]) begin
                if (ser_o !== 1'b0 || ser_oe_o !== 1'b0) bad++;
            end else begin
                if (loop_o !== 1'b0 || ser_oe_o !== 1'b1) bad++;
            end
            if (k == 5) begin
                word_i = ~cur[17:0];
                sync_i = ~cur[18];
            end
            if (k == 19) begin
                word_i    = nxt[17:0];
                sync_i    = nxt[18];
                loop_en_i = nxt[19];
            end
        end
        chk(got_f[0] === 1'b1, "R2 start bit", {31'd0, got_f[0]}, 32'd1);
        chk(got_f[19] === 1'b0, "R3 stop bit", {31'd0, got_f[19]}, 32'd0);
        if (cur[18])
            chk(got_f[18:1] === pl, "R5 sync pattern (R6 mid-frame)", {14'd0, got_f[18:1]}, {14'd0, pl});
        else
            chk(got_f[18:1] === pl, "R4 payload order (R6 mid-frame)", {14'd0, got_f[18:1]}, {14'd0, pl});
        chk(got_e === exp_e, "R7 run marker", {12'd0, got_e}, {12'd0, exp_e});
        chk(got_t === 20'h80000, "R1 tick position", {12'd0, got_t}, 32'h80000);
        chk(got_w === 20'h003FF, "R10 word clock", {12'd0, got_w}, 32'h3FF);
        chk(bad == 0, "R8 loopback routing", bad, 32'd0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R9 reset idle levels");
        rst_n     = 1'b1;
        word_i    = VEC[0][17:0];
        sync_i    = VEC[0][18];
        loop_en_i = VEC[0][19];
        exp_prev  = 1'b0;
        for (int i = 0; i < NV; i++)
            run_frame(VEC[i], (i == NV - 1) ? 20'h0 : VEC[i+1]);

        // Directed: reset in the middle of a frame, then restart (R9).
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_idle("R9 mid-frame reset");
        rst_n    = 1'b1;
        word_i   = 18'h25A5A;
        sync_i   = 1'b0;
        exp_prev = 1'b0;
        run_frame({2'b00, 18'h25A5A}, {2'b01, 18'h3FFFF});
        // Directed: sync over a payload of all ones gives the pattern (R5).
        run_frame({2'b01, 18'h3FFFF}, 20'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule